// File: doc/BRIEF.md
# HDLC-like frame transmitter

This block turns a stream of packets into a continuous octet stream for a byte-wide link. Packets arrive one octet at a time on a packet interface with start, end, valid and error markers. The block computes a 32-bit frame check sequence over the raw payload and byte-stuffs any octet that would be taken for a flag or an escape, including the check-sequence octets. It closes each frame with a flag and fills the time between frames with further flags, so the link always receives a valid stream.

The link side pulls data: each clock on which it raises its request, the block produces exactly one new octet. The source is held off whenever the octet being produced does not come from it: the second half of an escape pair, the check-sequence octets and the closing flag. A packet ended with an error, or a source that runs dry in the middle of a frame, ends the frame with an abort pair. An optional self-synchronizing scrambler covers the whole output, flags included.

Top module: `hdlc_frame_tx`

## Requirements
- R1: `link_data` resets to 0x00. On each rising edge with `link_req` high it takes the next octet of the output stream, and with `link_req` low it holds its value.
- R2: The first octet after reset is the flag 0x7E. While no packet start is offered the block keeps sending 0x7E. Every frame ends with a closing 0x7E, so at least one flag lies between any two frames.
- R3: A payload or check-sequence octet equal to 0x7E or 0x7D is sent as 0x7D followed by the octet XOR 0x20. All other octets are sent unchanged.
- R4: The check sequence is CRC-32 (reflected polynomial 0xEDB88320, preset 0xFFFFFFFF, octets taken LSB first) over the unstuffed payload. It is sent complemented, least significant octet first, right after the last payload octet. For the payload "123456789" the four octets are 0x26 0x39 0xF4 0xCB.
- R5: `pkt_ready` is high only while `link_req` is high. It is low while the block sends the second octet of an escape pair, a check-sequence octet, a closing flag or the second octet of an abort.
- R6: An octet offered with both `pkt_eop` and `pkt_err` is consumed but not sent. The frame ends with 0x7D 0x7E, with no check sequence.
- R7: If `pkt_valid` is low on a link slot inside a frame, the frame is aborted with 0x7D 0x7E.
- R8: Outside a frame, an octet offered without `pkt_sop` is consumed and dropped, and a flag is sent in that slot.
- R9: With `scr_en` high, each octet is scrambled MSB first as s = d XOR (the scrambled bit sent 43 bits earlier). The bit history is zero after reset and covers flags as well as frames. With `scr_en` low, octets pass unscrambled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scr_en | input | 1 | Scrambler enable, held static outside reset |
| link_req | input | 1 | Link asks for one octet at this edge |
| link_data | output | 8 | Octet delivered to the link |
| pkt_valid | input | 1 | Packet octet offered |
| pkt_data | input | 8 | Packet octet |
| pkt_sop | input | 1 | Offered octet starts a packet |
| pkt_eop | input | 1 | Offered octet ends a packet |
| pkt_err | input | 1 | Packet ending here is bad |
| pkt_ready | output | 1 | Offered octet is taken at this edge |

## Verification
The hardest situation to reach is an escape pair whose second octet lands on a slot where `link_req` drops, while the source is offering its last octet. Only there do the stall, the held output and the move into the check sequence all interact. The stimulus walks packets built to contain 0x7D and 0x7E runs at their ends, and throttles `link_req` in a fixed cycle pattern for some of them. This makes the escape tails line up with idle slots. A descrambler in the bench checks the same packets again with the scrambler on.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam logic [7:0] FLAG_OCT = 8'h7E;
  localparam logic [7:0] ESC_OCT  = 8'h7D;
  localparam logic [7:0] ESC_MASK = 8'h20;

  typedef enum logic [2:0] {
    ST_FLAG, ST_IDLE, ST_DATA, ST_ESC, ST_FCS, ST_ABRT
  } tx_state_e;

  function automatic logic needs_escape(input logic [7:0] b);
    return (b == FLAG_OCT) || (b == ESC_OCT);
  endfunction

  // One octet of reflected CRC, bit-serial, LSB first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c,
                                             input logic [7:0] b,
                                             input logic [31:0] poly);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs #(
  parameter logic [31:0] POLY = 32'hEDB88320,
  parameter logic [31:0] INIT = 32'hFFFFFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd,
  input  logic        restart,
  input  logic [7:0]  data,
  output logic [31:0] crc
);
  import hdlc_tx_pkg::*;
  logic [31:0] crc_q;
  always_ff @(posedge clk) begin
    if (!rst_n)   crc_q <= INIT;
    else if (upd) crc_q <= crc32_step(restart ? INIT : crc_q, data, POLY);
  end
  assign crc = crc_q;
endmodule

// File: rtl/hdlc_tx_scrambler.sv
module hdlc_tx_scrambler #(
  parameter int LAG = 43
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_req,
  input  logic       scr_en,
  input  logic [7:0] raw_oct,
  output logic [7:0] link_data
);
  logic [LAG-1:0] hist_q, hist_d;
  logic [7:0]     scr_oct;

  always_comb begin
    hist_d  = hist_q;
    scr_oct = '0;
    for (int i = 7; i >= 0; i--) begin
      scr_oct[i] = raw_oct[i] ^ hist_d[LAG-1];
      hist_d     = {hist_d[LAG-2:0], scr_oct[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q    <= '0;
      link_data <= '0;
    end else if (link_req) begin
      if (scr_en) begin
        hist_q    <= hist_d;
        link_data <= scr_oct;
      end else begin
        link_data <= raw_oct;
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl #(
  parameter int FCS_BYTES = 4,
  localparam int IDX_W = $clog2(FCS_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   link_req,
  input  logic                   pkt_valid,
  input  logic [7:0]             pkt_data,
  input  logic                   pkt_sop,
  input  logic                   pkt_eop,
  input  logic                   pkt_err,
  input  logic [8*FCS_BYTES-1:0] crc,
  output logic                   pkt_ready,
  output logic [7:0]             raw_oct,
  output logic                   crc_upd,
  output logic                   crc_restart,
  output logic                   esc_lead,
  output logic                   esc_tail,
  output logic                   fcs_slot,
  output logic                   flag_slot,
  output logic                   abort_lead
);
  import hdlc_tx_pkg::*;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FCS_BYTES - 1);

  tx_state_e        st_q, st_d, ret_q, ret_d;
  logic [7:0]       esc_q, esc_d, fcs_oct;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             in_frame, starts, upd_c;

  assign in_frame = (st_q == ST_DATA);
  assign starts   = pkt_valid && (in_frame || pkt_sop);
  assign fcs_oct  = ~crc[idx_q*8 +: 8];

  always_comb begin
    st_d        = st_q;
    ret_d       = ret_q;
    esc_d       = esc_q;
    idx_d       = idx_q;
    raw_oct     = FLAG_OCT;
    upd_c       = 1'b0;
    crc_restart = 1'b0;
    esc_lead    = 1'b0;
    abort_lead  = 1'b0;
    unique case (st_q)
      ST_FLAG: st_d = ST_IDLE;
      ST_IDLE, ST_DATA: begin
        if ((in_frame && !pkt_valid) || (starts && pkt_eop && pkt_err)) begin
          raw_oct    = ESC_OCT;
          abort_lead = 1'b1;
          st_d       = ST_ABRT;
        end else if (starts) begin
          upd_c       = 1'b1;
          crc_restart = !in_frame;
          idx_d       = '0;
          ret_d       = pkt_eop ? ST_FCS : ST_DATA;
          if (needs_escape(pkt_data)) begin
            raw_oct  = ESC_OCT;
            esc_d    = pkt_data ^ ESC_MASK;
            esc_lead = 1'b1;
            st_d     = ST_ESC;
          end else begin
            raw_oct = pkt_data;
            st_d    = ret_d;
          end
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_ESC: begin
        raw_oct = esc_q;
        st_d    = ret_q;
      end
      ST_FCS: begin
        idx_d = idx_q + 1'b1;
        ret_d = (idx_q == LAST_IDX) ? ST_FLAG : ST_FCS;
        if (needs_escape(fcs_oct)) begin
          raw_oct  = ESC_OCT;
          esc_d    = fcs_oct ^ ESC_MASK;
          esc_lead = 1'b1;
          st_d     = ST_ESC;
        end else begin
          raw_oct = fcs_oct;
          st_d    = ret_d;
        end
      end
      ST_ABRT: st_d = ST_IDLE;
      default: st_d = ST_FLAG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_FLAG;
      ret_q <= ST_IDLE;
      esc_q <= '0;
      idx_q <= '0;
    end else if (link_req) begin
      st_q  <= st_d;
      ret_q <= ret_d;
      esc_q <= esc_d;
      idx_q <= idx_d;
    end
  end

  assign pkt_ready = link_req && (st_q == ST_IDLE || st_q == ST_DATA);
  assign crc_upd   = upd_c && link_req;
  assign esc_tail  = (st_q == ST_ESC);
  assign fcs_slot  = (st_q == ST_FCS);
  assign flag_slot = (st_q == ST_FLAG) || (st_q == ST_ABRT) ||
                     (st_q == ST_IDLE && !(pkt_valid && pkt_sop));
endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx #(
  parameter logic [31:0] CRC_POLY = 32'hEDB88320,
  parameter logic [31:0] CRC_INIT = 32'hFFFFFFFF,
  parameter int          SCR_LAG  = 43
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scr_en,
  input  logic       link_req,
  output logic [7:0] link_data,
  input  logic       pkt_valid,
  input  logic [7:0] pkt_data,
  input  logic       pkt_sop,
  input  logic       pkt_eop,
  input  logic       pkt_err,
  output logic       pkt_ready
);
  localparam int FCS_BYTES = $bits(CRC_POLY) / 8;

  logic [31:0] crc;
  logic [7:0]  raw_oct;
  logic        crc_upd, crc_restart;
  // named events for the checker
  logic        esc_lead, esc_tail, fcs_slot, flag_slot, abort_lead;

  hdlc_tx_ctrl #(.FCS_BYTES(FCS_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .link_req(link_req),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_sop(pkt_sop),
    .pkt_eop(pkt_eop), .pkt_err(pkt_err), .crc(crc),
    .pkt_ready(pkt_ready), .raw_oct(raw_oct), .crc_upd(crc_upd),
    .crc_restart(crc_restart), .esc_lead(esc_lead), .esc_tail(esc_tail),
    .fcs_slot(fcs_slot), .flag_slot(flag_slot), .abort_lead(abort_lead)
  );

  hdlc_tx_fcs #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_fcs (
    .clk(clk), .rst_n(rst_n), .upd(crc_upd), .restart(crc_restart),
    .data(pkt_data), .crc(crc)
  );

  hdlc_tx_scrambler #(.LAG(SCR_LAG)) u_scr (
    .clk(clk), .rst_n(rst_n), .link_req(link_req), .scr_en(scr_en),
    .raw_oct(raw_oct), .link_data(link_data)
  );
endmodule

// File: rtl/hdlc_frame_tx_chk.sv
module hdlc_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scr_en,
  input logic       link_req,
  input logic       pkt_ready,
  input logic [7:0] link_data,
  input logic       esc_lead,
  input logic       esc_tail,
  input logic       fcs_slot,
  input logic       flag_slot,
  input logic       abort_lead
);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !link_req |=> $stable(link_data));
  a_r5_stall_esc: assert property (@(posedge clk) disable iff (!rst_n)
    esc_tail |-> !pkt_ready);
  a_r5_stall_fcs: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_slot |-> !pkt_ready);
  a_r3_esc_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (link_req && esc_lead && !scr_en) |=> link_data == 8'h7D);
  a_r2_flag_out: assert property (@(posedge clk) disable iff (!rst_n)
    (link_req && flag_slot && !scr_en) |=> link_data == 8'h7E);
  a_r6_abort_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (link_req && abort_lead && !scr_en) |=> link_data == 8'h7D);
endmodule

bind hdlc_frame_tx hdlc_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scr_en(scr_en), .link_req(link_req),
  .pkt_ready(pkt_ready), .link_data(link_data), .esc_lead(esc_lead),
  .esc_tail(esc_tail), .fcs_slot(fcs_slot), .flag_slot(flag_slot),
  .abort_lead(abort_lead)
);

// File: tb/test_hdlc_frame_tx.sv
`timescale 1ns/100ps
module test_hdlc_frame_tx;
  logic clk = 1'b0, rst_n = 1'b0, scr_en = 1'b0, link_req = 1'b0;
  logic pkt_valid = 1'b0, pkt_sop = 1'b0, pkt_eop = 1'b0, pkt_err = 1'b0;
  logic [7:0] pkt_data = '0;
  logic [7:0] link_data;
  logic pkt_ready;

  always #2.5 clk = ~clk;

  hdlc_frame_tx i_hdlc_frame_tx (
    .clk(clk), .rst_n(rst_n), .scr_en(scr_en), .link_req(link_req),
    .link_data(link_data), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .pkt_err(pkt_err),
    .pkt_ready(pkt_ready)
  );

  // packet table: [31:24] length, [23:16] first octet, [15:8] step, [1] error end, [0] throttle
  localparam logic [31:0] PKTS [8] = '{
    32'h01_11_00_00, 32'h04_7D_01_01, 32'h10_00_13_00, 32'h03_7E_00_00,
    32'h05_40_03_02, 32'h14_A0_07_01, 32'h02_5E_20_00, 32'h09_31_11_03
  };

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] tx_buf [64];
  logic       tx_sop [64], tx_eop [64], tx_err [64];
  int tx_len = 0, tx_ptr = 0;
  logic [7:0] q [256];
  int q_head = 0, q_tail = 0;
  logic at_start = 1'b1;
  logic [42:0] rx_hist = '0;
  logic [7:0] rx_last [5];

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nib_step(input logic [3:0] k);
    logic [31:0] v = {28'h0, k};
    for (int i = 0; i < 4; i++) v = v[0] ? ((v >> 1) ^ 32'hEDB88320) : (v >> 1);
    return v;
  endfunction

  function automatic logic [31:0] tb_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c ^ {24'h0, b};
    for (int n = 0; n < 2; n++) r = (r >> 4) ^ nib_step(r[3:0]);
    return r;
  endfunction

  task automatic push(input logic [7:0] b);
    q[q_tail] = b; q_tail++;
  endtask

  task automatic push_stuffed(input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) begin push(8'h7D); push(b ^ 8'h20); end
    else push(b);
  endtask

  task automatic see(input logic [7:0] s);
    logic [7:0] d;
    d = s;
    if (scr_en) for (int i = 7; i >= 0; i--) begin
      d[i] = s[i] ^ rx_hist[42];
      rx_hist = {rx_hist[41:0], s[i]};
    end
    for (int i = 0; i < 4; i++) rx_last[i] = rx_last[i+1];
    rx_last[4] = d;
    if (at_start && d == 8'h7E) chk(1'b1, "", 0, 0);
    else if (q_head == q_tail) chk(1'b0, "R2 stray octet", {24'h0, d}, 32'h7E);
    else begin
      chk(d == q[q_head], "R3 R4 R6 R7 R9 stream octet", {24'h0, d}, {24'h0, q[q_head]});
      at_start = (q[q_head] == 8'h7E);
      q_head++;
    end
  endtask

  task automatic step(input logic req);
    logic took;
    @(negedge clk);
    link_req = req;
    if (tx_ptr < tx_len) begin
      pkt_valid = 1'b1; pkt_data = tx_buf[tx_ptr];
      pkt_sop = tx_sop[tx_ptr]; pkt_eop = tx_eop[tx_ptr]; pkt_err = tx_err[tx_ptr];
    end else begin
      pkt_valid = 1'b0; pkt_sop = 1'b0; pkt_eop = 1'b0; pkt_err = 1'b0;
    end
    #1;
    took = pkt_valid && pkt_ready;
    if (!req) chk(!pkt_ready, "R5 ready without request", {31'h0, pkt_ready}, 0);
    @(posedge clk); #1;
    if (took) tx_ptr++;
    if (req) see(link_data);
    cyc++;
  endtask

  task automatic drain(input logic thr);
    for (int k = 0; k < 400; k++) begin
      if (tx_ptr == tx_len && q_head == q_tail) break;
      step(thr ? (cyc % 3 != 0) : 1'b1);
    end
    chk(tx_ptr == tx_len && q_head == q_tail, "R1 frame drained", q_tail - q_head, 0);
  endtask

  task automatic load_entry(input logic [31:0] e);
    int len = int'(e[31:24]);
    logic [7:0] b;
    logic [31:0] c = 32'hFFFFFFFF;
    tx_len = len; tx_ptr = 0; q_head = 0; q_tail = 0;
    for (int i = 0; i < len; i++) begin
      b = e[23:16] + 8'(i) * e[15:8];
      tx_buf[i] = b; tx_sop[i] = (i == 0); tx_eop[i] = (i == len - 1);
      tx_err[i] = (i == len - 1) && e[1];
      if (!tx_err[i]) begin push_stuffed(b); c = tb_crc(c, b); end
    end
    if (e[1]) begin push(8'h7D); push(8'h7E); end
    else begin
      c = ~c;
      for (int i = 0; i < 4; i++) push_stuffed(c[8*i +: 8]);
      push(8'h7E);
    end
  endtask

  task automatic do_reset(input logic scr);
    @(negedge clk);
    rst_n = 1'b0; link_req = 1'b0; scr_en = scr;
    tx_len = 0; tx_ptr = 0; q_head = 0; q_tail = 0; at_start = 1'b1; rx_hist = '0;
    repeat (3) @(negedge clk);
    chk(link_data == 8'h00, "R1 reset value", {24'h0, link_data}, 0);
    chk(!pkt_ready, "R5 ready in reset", {31'h0, pkt_ready}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_table();
    for (int p = 0; p < 8; p++) begin
      load_entry(PKTS[p]);
      drain(PKTS[p][0]);
      if (PKTS[p][1])
        chk(rx_last[3] == 8'h7D && rx_last[4] == 8'h7E, "R6 abort pair",
            {rx_last[3], rx_last[4]}, 32'h7D7E);
      else
        chk(rx_last[4] == 8'h7E, "R2 closing flag", {24'h0, rx_last[4]}, 32'h7E);
      step(1'b1);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] held;
    do_reset(1'b0);
    step(1'b1);
    chk(link_data == 8'h7E, "R2 first octet is flag", {24'h0, link_data}, 32'h7E);
    repeat (3) step(1'b1);
    chk(link_data == 8'h7E, "R2 idle flag", {24'h0, link_data}, 32'h7E);

    // R8: octet without start marker outside a frame
    tx_buf[0] = 8'h55; tx_sop[0] = 1'b0; tx_eop[0] = 1'b1; tx_err[0] = 1'b0;
    tx_len = 1; tx_ptr = 0;
    step(1'b1);
    chk(tx_ptr == 1, "R8 stray octet consumed", tx_ptr, 1);
    chk(link_data == 8'h7E, "R8 flag sent for stray", {24'h0, link_data}, 32'h7E);

    run_table();

    // R4: known check value
    tx_len = 9; tx_ptr = 0; q_head = 0; q_tail = 0;
    for (int i = 0; i < 9; i++) begin
      tx_buf[i] = 8'h31 + 8'(i); tx_sop[i] = (i == 0); tx_eop[i] = (i == 8); tx_err[i] = 1'b0;
      push(tx_buf[i]);
    end
    push(8'h26); push(8'h39); push(8'hF4); push(8'hCB); push(8'h7E);
    drain(1'b0);
    chk({rx_last[0], rx_last[1], rx_last[2], rx_last[3]} == 32'h2639F4CB, "R4 check value",
        {rx_last[0], rx_last[1], rx_last[2], rx_last[3]}, 32'h2639F4CB);

    // R7: source runs dry inside a frame
    tx_len = 3; tx_ptr = 0; q_head = 0; q_tail = 0;
    tx_buf[0] = 8'h10; tx_buf[1] = 8'h7E; tx_buf[2] = 8'h20;
    for (int i = 0; i < 3; i++) begin tx_sop[i] = (i == 0); tx_eop[i] = 1'b0; tx_err[i] = 1'b0; end
    push(8'h10); push(8'h7D); push(8'h5E); push(8'h20); push(8'h7D); push(8'h7E);
    drain(1'b0);
    chk(rx_last[3] == 8'h7D && rx_last[4] == 8'h7E, "R7 underrun abort",
        {rx_last[3], rx_last[4]}, 32'h7D7E);

    // R9: same traffic scrambled
    do_reset(1'b1);
    repeat (6) step(1'b1);
    held = link_data;
    repeat (3) step(1'b0);
    chk(link_data == held, "R1 hold without request", {24'h0, link_data}, {24'h0, held});
    run_table();
    chk(q_head == q_tail, "R9 scrambled run complete", q_tail - q_head, 0);

    summary();
    $finish;
  end
endmodule